// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive approximation converter. Once it is started, it asks an external sample-and-hold to freeze the analog input. It then resolves the output code by binary search, one bit per clock, beginning with the most significant bit. Each trial code goes out to an external DAC. A single comparator bit comes back and reports whether the held input lies at or above the trial level. That bit decides whether the bit under test stays set.

When the least significant bit has been decided, the finished code is copied into a published result register that is separate from the trial register, and a one-clock done strobe is raised. The result therefore stays steady while a later search is still running. After done, the controller either returns to idle and waits for the next start, or, when continuous mode is selected, begins a new sample at once. The resolution is a parameter.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `trial_o`, `result_o`, `done_o`, `sample_o` and `busy_o` are all zero.
- R2: A `start_i` seen at a clock edge while idle raises `sample_o` for exactly one cycle, which begins at that edge. `busy_o` is high from that cycle on.
- R3: The first trial after the sample pulse has only the MSB set (the value 2^(W-1)). Every other trial bit is cleared at that point.
- R4: In each search cycle, a high `cmp_i` keeps the bit under test set and a low `cmp_i` clears it. The next lower bit is then set as the new trial. A high reading therefore raises `trial_o` unless the LSB was the bit under test, and a low reading always lowers it.
- R5: `done_o` is high for exactly one cycle, W+1 clock edges after the edge that samples `start_i`. `result_o` takes the new code at that same edge.
- R6: With an ideal DAC and comparator, where `cmp_i` = 1 when the held input is greater than or equal to trial × FS / 2^W, `result_o` equals floor(vin × 2^W / FS) for every input level from 0 up to just below full scale.
- R7: `result_o` changes only at an edge where `done_o` becomes high. It keeps the previous code for the whole of a following search.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running conversion keeps its timing and result, and no extra conversion follows it.
- R9: If `cont_i` is high at the final decision edge, the sample pulse coincides with the done cycle and the next `done_o` follows W+1 edges later. If `cont_i` is low at that edge, the controller goes idle and `busy_o` falls together with the rise of `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a conversion (only honoured while idle) |
| cont_i | input | 1 | Continuous mode: restart right after each done |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the trial level |
| sample_o | output | 1 | One-cycle acquire strobe to the external sample-and-hold |
| trial_o | output | W | Trial code driven to the external DAC |
| busy_o | output | 1 | Sample or search in progress |
| result_o | output | W | Last completed conversion code |
| done_o | output | 1 | One-cycle strobe marking a new `result_o` |

## Verification
The bound checker covers the properties that are local in time on every cycle. It confirms that the sample strobe lasts a single cycle, that the trial after it holds only the MSB, and that each comparator reading moves the trial in the correct direction. It also checks that done is a single-cycle strobe and that the published result never changes except together with done. The directed scenarios cover what needs a model of the analog side: exact codes for every input level, the full bit-by-bit trial sequence, exact latency, and the dropping of a start request during a search. They also cover result stability and cycle spacing across back-to-back continuous conversions, and the return to idle once continuous mode is withdrawn.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_SEARCH = 2'd2
    } phase_e;

    // Per-cycle commands from the sequencer to the datapath
    typedef struct packed {
        logic load;    // reset trial to MSB-only, arm bit pointer
        logic step;    // decide the bit under test
    } sar_ctl_s;

    function automatic logic is_busy(input phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     cont_i,
    input  logic     last_i,
    output phase_e   phase_o,
    output sar_ctl_s ctl_o
);

    phase_e phase_q, phase_n;

    always_comb begin
        phase_n = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start_i) phase_n = PH_SAMPLE;
            PH_SAMPLE: phase_n = PH_SEARCH;
            PH_SEARCH: if (last_i) phase_n = cont_i ? PH_SAMPLE : PH_IDLE;
            default:   phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_n;
    end

    assign ctl_o.load = (phase_q == PH_SAMPLE);
    assign ctl_o.step = (phase_q == PH_SEARCH);
    assign phase_o    = phase_q;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] decided_o,
    output logic         last_o
);

    localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] trial_q;
    logic [W-1:0] mask_q;     // one-hot: bit under test
    logic [W-1:0] trial_n;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic promote;        // bit above is being decided now, this one is next trial
        if (i == W - 1) begin : g_top
            assign promote = 1'b0;
        end else begin : g_low
            assign promote = mask_q[i+1];
        end
        assign trial_n[i] = mask_q[i] ? cmp_i : (promote | trial_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= '0;
            mask_q  <= '0;
        end else if (load_i) begin
            trial_q <= TOP_ONLY;
            mask_q  <= TOP_ONLY;
        end else if (step_i) begin
            trial_q <= trial_n;
            mask_q  <= mask_q >> 1;
        end
    end

    assign trial_o   = trial_q;
    assign decided_o = trial_n;
    assign last_o    = mask_q[0];

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    logic [W-1:0] result_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= capture_i;
            if (capture_i) result_q <= code_i;
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         cont_i,
    input  logic         cmp_i,
    output logic         sample_o,
    output logic [W-1:0] trial_o,
    output logic         busy_o,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    phase_e       phase;
    sar_ctl_s     ctl;
    logic         last;
    logic [W-1:0] decided;

    sar_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cont_i  (cont_i),
        .last_i  (last),
        .phase_o (phase),
        .ctl_o   (ctl)
    );

    sar_trial_reg #(.W(W)) u_trial (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctl.load),
        .step_i    (ctl.step),
        .cmp_i     (cmp_i),
        .trial_o   (trial_o),
        .decided_o (decided),
        .last_o    (last)
    );

    sar_result_reg #(.W(W)) u_result (
        .clk       (clk),
        .rst       (rst),
        .capture_i (ctl.step & last),
        .code_i    (decided),
        .result_o  (result_o),
        .done_o    (done_o)
    );

    assign sample_o = ctl.load;
    assign busy_o   = is_busy(phase);

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cmp_i,
    input logic         sample_o,
    input logic [W-1:0] trial_o,
    input logic         busy_o,
    input logic [W-1:0] result_o,
    input logic         done_o
);

    localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

    assert_sample_single_R2: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o);

    assert_first_trial_msb_R3: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> (trial_o == TOP_ONLY));

    assert_keep_raises_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !sample_o && cmp_i) |=> (done_o || (trial_o > $past(trial_o))));

    assert_clear_lowers_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !sample_o && !cmp_i) |=> (trial_o < $past(trial_o)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_result_only_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> done_o);

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmp_i    (cmp_i),
    .sample_o (sample_o),
    .trial_o  (trial_o),
    .busy_o   (busy_o),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/sar_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sar_seq_ctrl_bench;

    localparam int W    = 8;
    localparam int FRAC = 4;           // sub-LSB resolution of the analog model
    localparam int VW   = W + FRAC;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         cont_i = 1'b0;
    logic         cmp_i;
    logic         sample_o;
    logic [W-1:0] trial_o;
    logic         busy_o;
    logic [W-1:0] result_o;
    logic         done_o;

    logic [VW-1:0] vin = '0;   // analog input, full scale = 2^VW
    logic [VW-1:0] held = '0;  // sample-and-hold model

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sar_seq_ctrl #(.W(W)) u_sar_seq_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i), .cmp_i(cmp_i),
        .sample_o(sample_o), .trial_o(trial_o), .busy_o(busy_o),
        .result_o(result_o), .done_o(done_o)
    );

    // ideal S/H, DAC and comparator
    always @(posedge clk) if (sample_o) held <= vin;
    assign cmp_i = (held >= {trial_o, {FRAC{1'b0}}});

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ideal_code(input logic [VW-1:0] v);
        return int'(v >> FRAC);
    endfunction

    // start a conversion from idle; returns result and negedge count until done
    task automatic convert(input logic [VW-1:0] v, output int code, output int lat);
        vin = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        code = int'(result_o);
    endtask

    task automatic t_reset;
        chk(trial_o == 0,  "R1 trial",  int'(trial_o), 0);
        chk(result_o == 0, "R1 result", int'(result_o), 0);
        chk(done_o == 0,   "R1 done",   int'(done_o), 0);
        chk(sample_o == 0, "R1 sample", int'(sample_o), 0);
        chk(busy_o == 0,   "R1 busy",   int'(busy_o), 0);
    endtask

    // follow every trial code of one search
    task automatic t_trace(input logic [VW-1:0] v);
        int code;
        code = ideal_code(v);
        vin = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(sample_o == 1, "R2 sample pulse", int'(sample_o), 1);
        chk(busy_o == 1,   "R2 busy", int'(busy_o), 1);
        for (int k = 0; k < W; k++) begin
            int exp_t;
            @(negedge clk);
            exp_t = ((code >> (W - k)) << (W - k)) | (1 << (W - 1 - k));
            if (k == 0) chk(int'(trial_o) == exp_t, "R3 first trial", int'(trial_o), exp_t);
            else        chk(int'(trial_o) == exp_t, "R4 trial step", int'(trial_o), exp_t);
            chk(sample_o == 0, "R2 sample width", int'(sample_o), 0);
            chk(done_o == 0, "R5 early done", int'(done_o), 0);
        end
        @(negedge clk);
        chk(done_o == 1, "R5 done timing", int'(done_o), 1);
        chk(int'(result_o) == code, "R5 result", int'(result_o), code);
        chk(busy_o == 0, "R9 idle after done", int'(busy_o), 0);
        @(negedge clk);
        chk(done_o == 0, "R5 done width", int'(done_o), 0);
    endtask

    task automatic t_sweep;
        for (int c = 0; c < (1 << W); c++) begin
            int got, lat;
            logic [VW-1:0] v;
            v = VW'((c << FRAC) | ((c * 7) % (1 << FRAC)));
            convert(v, got, lat);
            chk(got == c, "R6 code", got, c);
            chk(lat == W + 2, "R5 latency", lat, W + 2);
            @(negedge clk);
        end
        begin
            int got, lat;
            convert({VW{1'b1}}, got, lat);
            chk(got == (1 << W) - 1, "R6 full scale", got, (1 << W) - 1);
            @(negedge clk);
            convert('0, got, lat);
            chk(got == 0, "R6 zero", got, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_ignore_start;
        int lat;
        vin = VW'(12'h5A3);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        start_i = 1'b1;        // request during search
        vin = VW'(12'h0F0);
        @(negedge clk); lat++;
        start_i = 1'b0;
        while (!done_o && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == W + 2, "R8 latency kept", lat, W + 2);
        chk(int'(result_o) == 8'h5A, "R8 result kept", int'(result_o), 8'h5A);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(sample_o == 0 && busy_o == 0, "R8 no extra conversion",
                int'({sample_o, busy_o}), 0);
        end
    endtask

    task automatic t_continuous;
        int got, lat, n;
        int first;
        cont_i = 1'b1;
        convert(VW'(12'h3C7), got, lat);
        first = got;
        chk(got == 8'h3C, "R9 first code", got, 8'h3C);
        chk(sample_o == 1, "R9 sample with done", int'(sample_o), 1);
        vin = VW'(12'hC41);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!done_o) chk(int'(result_o) == first, "R7 result held", int'(result_o), first);
        end while (!done_o && n < 100);
        chk(n == W + 1, "R9 restart spacing", n, W + 1);
        chk(int'(result_o) == 8'hC4, "R9 second code", int'(result_o), 8'hC4);
        cont_i = 1'b0;         // third conversion runs, then stop
        vin = VW'(12'h01F);
        n = 0;
        do begin @(negedge clk); n++; end while (!done_o && n < 100);
        chk(int'(result_o) == 8'h01, "R9 third code", int'(result_o), 8'h01);
        chk(busy_o == 0, "R9 idle when cont low", int'(busy_o), 0);
        repeat (4) begin
            @(negedge clk);
            chk(sample_o == 0, "R9 no restart", int'(sample_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trace(VW'(12'hB6E));
        @(negedge clk);
        t_trace(VW'(12'h40F));
        @(negedge clk);
        t_sweep();
        t_ignore_start();
        t_continuous();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule